// File: doc/BRIEF.md
# Up/Down BCD Digit Counter with Terminal Flag

This block is a synchronous single-digit decimal counter that moves through the values 0 to 9. On each rising clock edge it either loads a new digit from a parallel input, steps up, steps down, or keeps its value. Three control inputs pick the step: an active-low load strobe, an active-low count enable and a direction select. The load strobe has the highest priority.

A terminal flag shows when the digit is at the end of its range for the current direction. That end is 9 when counting up and 0 when counting down. An active-low ripple output is built from this flag, the enable and the low phase of the clock. Several digits can be chained by driving the enable of the next stage from the ripple output of the one before it.

Each clock edge applies one of four operations, chosen by a small decoder.

| Operation | Selected when | Effect on the digit |
|---|---|---|
| OP_LOAD | `load_n` is 0 | takes the value of `din` |
| OP_HOLD | `load_n` is 1 and `cnt_en_n` is 1 | keeps its value |
| OP_UP | `load_n` is 1, `cnt_en_n` is 0 and `dir_down` is 0 | steps up |
| OP_DOWN | `load_n` is 1, `cnt_en_n` is 0 and `dir_down` is 1 | steps down |

The digit moves between its values as follows:
- In OP_UP, the transition from 9 is to 0.
- In OP_DOWN, the transition from 0 is to 9.
- A loaded value from 10 to 15 is outside the legal range. The next OP_UP or OP_DOWN returns the digit to the legal range.

Top module: `bcd_updown_counter`

## Requirements
- R1: While `rst_n` is low, `q` is 0.
- R2: When `load_n` is 0 at a rising edge, `q` takes the value of `din` at that edge. This holds whatever the values of `cnt_en_n` and `dir_down`.
- R3: When `load_n` is 1 and `cnt_en_n` is 1 at a rising edge, `q` keeps its value.
- R4: When `load_n` is 1, `cnt_en_n` is 0 and `dir_down` is 0, `q` goes up by one at the edge. The value 9 goes to 0.
- R5: When `load_n` is 1, `cnt_en_n` is 0 and `dir_down` is 1, `q` goes down by one at the edge. The value 0 goes to 9.
- R6: A value from 10 to 15 in `q` goes to 0 on a step up and to 9 on a step down.
- R7: `term_flag` is 1 exactly when `dir_down` is 0 and `q` is 9, or when `dir_down` is 1 and `q` is 0. This does not depend on `cnt_en_n`.
- R8: `ripple_n` is 0 exactly when `cnt_en_n` is 0, `term_flag` is 1 and `clk` is low. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Rising edge is active. |
| rst_n | input | 1 | Asynchronous reset, active low. Clears the digit. |
| load_n | input | 1 | Parallel load strobe, active low. Has the highest priority. |
| cnt_en_n | input | 1 | Count enable, active low. |
| dir_down | input | 1 | Direction select: 0 counts up, 1 counts down. |
| din | input | 4 | Digit to load. |
| q | output | 4 | Current digit. |
| term_flag | output | 1 | Terminal flag for the current direction. |
| ripple_n | output | 1 | Ripple output for cascading, active low. |

## Verification
The assertions check these rules on every clock edge:
- the wrap from 9 to 0 and from 0 to 9;
- that a hold leaves the digit unchanged;
- that a load has priority;
- that every count step ends inside the legal range;
- that the ripple output stays high whenever the terminal flag is low.

Some behaviour can only be shown by the bench scenarios:
- the exact low window of `ripple_n`, which depends on the clock level;
- how a loaded out-of-range value recovers in each direction;
- that the terminal flag follows the direction select while the enable is off.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_UP   = 2'd2,
        OP_DOWN = 2'd3
    } ctr_op_e;
endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
    import bcd_ctr_pkg::*;
(
    input  logic    load_n,
    input  logic    cnt_en_n,
    input  logic    dir_down,
    output ctr_op_e op
);
    always_comb begin
        unique case ({load_n, cnt_en_n})
            2'b00, 2'b01: op = OP_LOAD;
            2'b11:        op = OP_HOLD;
            default:      op = dir_down ? OP_DOWN : OP_UP;
        endcase
    end
endmodule

// File: rtl/ctr_next_digit.sv
module ctr_next_digit
    import bcd_ctr_pkg::*;
#(
    parameter int DIGIT_W = 4,
    parameter int MODULUS = 10
) (
    input  ctr_op_e              op,
    input  logic [DIGIT_W-1:0]   cur,
    input  logic [DIGIT_W-1:0]   din,
    output logic [DIGIT_W-1:0]   nxt
);
    localparam logic [DIGIT_W-1:0] LAST_V = DIGIT_W'(MODULUS - 1);
    localparam logic [DIGIT_W-1:0] ONE_V  = DIGIT_W'(1);

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = din;
            OP_UP:   nxt = (cur >= LAST_V) ? '0 : cur + ONE_V;
            OP_DOWN: nxt = (cur == '0 || cur > LAST_V) ? LAST_V : cur - ONE_V;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_term_decode.sv
module ctr_term_decode #(
    parameter int DIGIT_W = 4,
    parameter int MODULUS = 10
) (
    input  logic               clk,
    input  logic [DIGIT_W-1:0] cur,
    input  logic               dir_down,
    input  logic               cnt_en_n,
    output logic               term_flag,
    output logic               ripple_n
);
    localparam logic [DIGIT_W-1:0] LAST_V = DIGIT_W'(MODULUS - 1);

    always_comb begin
        term_flag = dir_down ? (cur == '0) : (cur == LAST_V);
        ripple_n  = ~(~cnt_en_n & term_flag & ~clk);
    end
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
    import bcd_ctr_pkg::*;
#(
    parameter int DIGIT_W = 4,
    parameter int MODULUS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic               cnt_en_n,
    input  logic               dir_down,
    input  logic [DIGIT_W-1:0] din,
    output logic [DIGIT_W-1:0] q,
    output logic               term_flag,
    output logic               ripple_n
);
    localparam logic [DIGIT_W-1:0] LAST_V = DIGIT_W'(MODULUS - 1);

    ctr_op_e            op;
    logic [DIGIT_W-1:0] q_nxt;

    ctr_op_decode u_dec (
        .load_n   (load_n),
        .cnt_en_n (cnt_en_n),
        .dir_down (dir_down),
        .op       (op)
    );

    ctr_next_digit #(.DIGIT_W(DIGIT_W), .MODULUS(MODULUS)) u_nxt (
        .op  (op),
        .cur (q),
        .din (din),
        .nxt (q_nxt)
    );

    ctr_term_decode #(.DIGIT_W(DIGIT_W), .MODULUS(MODULUS)) u_term (
        .clk       (clk),
        .cur       (q),
        .dir_down  (dir_down),
        .cnt_en_n  (cnt_en_n),
        .term_flag (term_flag),
        .ripple_n  (ripple_n)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (q == $past(din)));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_n) |=> $stable(q));

    // R4
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !dir_down && q == LAST_V) |=> (q == '0));

    // R5
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && dir_down && q == '0) |=> (q == LAST_V));

    // R6
    step_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n) |=> (q <= LAST_V));

    // R8
    ripple_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !term_flag |-> ripple_n);
endmodule

// File: tb/sim_bcd_updown_counter.sv
module sim_bcd_updown_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic       cnt_en_n = 1'b1;
    logic       dir_down = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] q;
    logic       term_flag;
    logic       ripple_n;

    int checks = 0;
    int fails  = 0;
    logic [3:0] exp_q = 4'd0;

    always #10 clk = ~clk;

    bcd_updown_counter u0 (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_n(cnt_en_n),
        .dir_down(dir_down), .din(din), .q(q), .term_flag(term_flag),
        .ripple_n(ripple_n)
    );

    function automatic logic [3:0] f_next(input logic [3:0] cur, input logic ld_n,
                                          input logic en_n, input logic dn,
                                          input logic [3:0] d);
        if (!ld_n) return d;
        if (en_n) return cur;
        if (!dn) return (cur >= 4'd9) ? 4'd0 : cur + 4'd1;
        return (cur == 4'd0 || cur > 4'd9) ? 4'd9 : cur - 4'd1;
    endfunction

    function automatic logic f_flag(input logic [3:0] cur, input logic dn);
        return dn ? (cur == 4'd0) : (cur == 4'd9);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // apply inputs in the low phase, check flags, then take one edge
    task automatic step(input logic ld_n, input logic en_n, input logic dn,
                        input logic [3:0] d, input string req);
        @(negedge clk);
        #1;
        load_n = ld_n; cnt_en_n = en_n; dir_down = dn; din = d;
        #2;
        chk("R7", term_flag, f_flag(exp_q, dn));
        chk("R8", ripple_n, !(!en_n && f_flag(exp_q, dn)));
        @(posedge clk);
        #1;
        exp_q = f_next(exp_q, ld_n, en_n, dn, d);
        chk(req, q, exp_q);
        chk("R8", ripple_n, 1);
    endtask

    initial begin
        #(20 * 20000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        #35;
        chk("R1", q, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: load 7 with counting enabled, load must win
        step(1'b0, 1'b0, 1'b0, 4'd7, "R2");
        step(1'b1, 1'b1, 1'b0, 4'd3, "R3");
        step(1'b1, 1'b1, 1'b1, 4'd3, "R3");
        step(1'b1, 1'b0, 1'b0, 4'd0, "R4");
        step(1'b1, 1'b0, 1'b0, 4'd0, "R4");
        step(1'b1, 1'b0, 1'b0, 4'd0, "R4");
        // R5: load 1, step down across 0
        step(1'b0, 1'b1, 1'b1, 4'd1, "R2");
        step(1'b1, 1'b0, 1'b1, 4'd0, "R5");
        step(1'b1, 1'b0, 1'b1, 4'd0, "R5");
        step(1'b1, 1'b0, 1'b1, 4'd0, "R5");
        // R6: out-of-range loads
        step(1'b0, 1'b1, 1'b0, 4'd12, "R2");
        step(1'b1, 1'b0, 1'b0, 4'd0, "R6");
        step(1'b0, 1'b1, 1'b1, 4'd14, "R2");
        step(1'b1, 1'b0, 1'b1, 4'd0, "R6");
        step(1'b0, 1'b1, 1'b0, 4'd15, "R2");
        step(1'b1, 1'b1, 1'b1, 4'd0, "R3");
        step(1'b1, 1'b0, 1'b1, 4'd0, "R6");
        // R7: flag follows direction with enable off
        step(1'b0, 1'b1, 1'b0, 4'd0, "R2");
        step(1'b1, 1'b1, 1'b1, 4'd0, "R3");
        step(1'b1, 1'b1, 1'b0, 4'd0, "R3");
        for (int i = 0; i < 600; i++) begin
            logic ld, en, dn;
            ld = ($urandom % 8) != 0;
            en = ($urandom % 4) == 0;
            dn = $urandom % 2;
            step(ld, en, dn, 4'($urandom % 16), !ld ? "R2" : en ? "R3" : dn ? "R5" : "R4");
        end
        rst_n = 1'b0;
        #1;
        chk("R1", q, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule